// File: doc/BRIEF.md
# Arithmetic Flag Generation Unit

This unit adds or subtracts two operands, with or without an incoming carry, at either byte or word width. It returns the result combinationally and keeps six status flags in a register. The flags are carry, parity, half carry, zero, sign and overflow.

The register loads new flags on a rising clock edge when the update enable is high and the operation is arithmetic. Three commands change only the carry flag: set it, clear it, or invert it. A move operation passes the second operand through and leaves every flag alone. The unit is meant to sit in the execute stage of a small integer datapath. Decode supplies the operation code, the size select and the flag-write strobe.

Top module: `arith_flag_unit`

## Requirements
- R1: `op_i` selects the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow (`carry_i` is the borrow), 4 set carry, 5 clear carry, 6 invert carry, 7 move. For codes 0 to 3, `result_o` is the combinational result modulo 2^16 when `byte_i` = 0. When `byte_i` = 1, only the low bytes of the operands are used and `result_o[15:8]` is 0. `carry_i` has no effect on codes 0 and 2.
- R2: `flags_o[0]` (carry) holds the carry out of bit 7 (byte mode) or bit 15 (word mode) after an addition, and the borrow after a subtraction.
- R3: `flags_o[1]` (parity) is 1 when `result_o[7:0]` has an even number of ones, including zero ones, in both sizes.
- R4: `flags_o[2]` (half carry) is the carry or borrow from bit 3 into bit 4, with the carry or borrow input included.
- R5: `flags_o[3]` (zero) is 1 exactly when the result is zero.
- R6: `flags_o[4]` (sign) is bit 7 of the result in byte mode and bit 15 in word mode.
- R7: `flags_o[5]` (overflow) is 1 on two's-complement overflow at the selected size. For example, 0x7F + 0x01 in byte mode gives 0x80 with overflow set.
- R8: For codes 0 to 3, the flags register loads on the rising clock edge when `upd_en_i` is high. It holds all six bits when `upd_en_i` is low, whatever the operation.
- R9: With `upd_en_i` high, code 4 sets the carry flag, code 5 clears it and code 6 inverts it. Bits 5:1 of `flags_o` do not change.
- R10: Code 7 drives `result_o` with `b_i` (low byte only, upper byte zero, in byte mode). It leaves all flags unchanged even when `upd_en_i` is high.
- R11: Driving `rst_ni` low clears `flags_o` to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| byte_i | input | 1 | 1 = byte size, 0 = word size |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand (subtrahend) |
| carry_i | input | 1 | Carry or borrow in for codes 1 and 3 |
| upd_en_i | input | 1 | Flag register write enable |
| result_o | output | 16 | Combinational result |
| flags_o | output | 6 | Registered flags {overflow, sign, zero, half carry, parity, carry} |

## Verification
The assertions assume that `op_i`, `byte_i` and the operands stay stable across each rising edge at which flags are sampled. They also assume reset is released away from a clock edge. The bench meets both conditions by changing every input on the falling edge only. It drops and raises `rst_ni` between edges as well.

The byte sweep walks both operands across their full range with coprime strides, over all four arithmetic codes. It alternates the carry input so that both values of every flag are reached. Word mode is driven from a linear-feedback sequence, plus fixed corner operands at the sign and carry boundaries.

// File: rtl/flag_pkg.sv
package flag_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_STC  = 3'd4,
    OP_CLC  = 3'd5,
    OP_CMC  = 3'd6,
    OP_MOVE = 3'd7
  } op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/arith_core.sv
module arith_core
  import flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  op_e               op_i,
  input  logic              byte_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output flags_t            flags_o
);
  localparam int LOW_W = DATA_W / 2;
  localparam int EXT_W = DATA_W + 1;
  localparam int NIB   = 4;

  logic [2:0]        opc;
  logic [DATA_W-1:0] am, bm;
  logic [EXT_W-1:0]  total;
  logic              cin_eff, is_sub, sa, sb, sr;

  always_comb begin
    opc     = op_i;
    is_sub  = opc[1];
    am      = byte_i ? {{(DATA_W-LOW_W){1'b0}}, a_i[LOW_W-1:0]} : a_i;
    bm      = byte_i ? {{(DATA_W-LOW_W){1'b0}}, b_i[LOW_W-1:0]} : b_i;
    cin_eff = opc[0] & carry_i;
    if (is_sub) total = {1'b0, am} - {1'b0, bm} - EXT_W'(cin_eff);
    else        total = {1'b0, am} + {1'b0, bm} + EXT_W'(cin_eff);

    if (opc[2])      result_o = bm;
    else if (byte_i) result_o = {{(DATA_W-LOW_W){1'b0}}, total[LOW_W-1:0]};
    else             result_o = total[DATA_W-1:0];

    sa = byte_i ? am[LOW_W-1] : am[DATA_W-1];
    sb = byte_i ? bm[LOW_W-1] : bm[DATA_W-1];
    sr = byte_i ? total[LOW_W-1] : total[DATA_W-1];

    // borrow is the wrapped top bit of the extended difference
    flags_o.cry = byte_i ? total[LOW_W] : total[DATA_W];
    flags_o.par = ~^result_o[7:0];
    flags_o.aux = am[NIB] ^ bm[NIB] ^ total[NIB];
    flags_o.zro = (result_o == '0);
    flags_o.sgn = sr;
    flags_o.ovf = is_sub ? ((sa ^ sb) & (sr ^ sa)) : (~(sa ^ sb) & (sr ^ sa));
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_en_i,
  input  op_e    op_i,
  input  flags_t next_i,
  output flags_t flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
    end else if (upd_en_i) begin
      unique case (op_i)
        OP_ADD, OP_ADC, OP_SUB, OP_SBB: flags_o <= next_i;
        OP_STC:  flags_o.cry <= 1'b1;
        OP_CLC:  flags_o.cry <= 1'b0;
        OP_CMC:  flags_o.cry <= ~flags_o.cry;
        default: ;
      endcase
    end
  end

  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(flags_o));

  a_r9_stc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && op_i == OP_STC) |=> flags_o.cry);

  a_r9_clc_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && op_i == OP_CLC) |=> !flags_o.cry);

  a_r9_cmc_inverts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && op_i == OP_CMC) |=> flags_o.cry != $past(flags_o.cry));

  a_r9_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && (op_i == OP_STC || op_i == OP_CLC || op_i == OP_CMC))
      |=> flags_o[FLAG_W-1:1] == $past(flags_o[FLAG_W-1:1]));

  a_r10_move_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MOVE) |=> $stable(flags_o));
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic              upd_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic [5:0]        flags_o
);
  localparam int LOW_W = DATA_W / 2;

  op_e    op_w;
  flags_t next_w, flags_q;

  assign op_w = op_e'(op_i);

  arith_core #(.DATA_W(DATA_W)) u_core (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_w),
    .byte_i  (byte_i),
    .carry_i (carry_i),
    .result_o(result_o),
    .flags_o (next_w)
  );

  flag_reg u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_en_i(upd_en_i),
    .op_i    (op_w),
    .next_i  (next_w),
    .flags_o (flags_q)
  );

  assign flags_o = flags_q;

  a_r1_byte_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |-> result_o[DATA_W-1:LOW_W] == '0);

  a_r5_zero_tracks_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !op_i[2]) |=> flags_o[3] == ($past(result_o) == '0));

  a_r6_sign_tracks_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !op_i[2]) |=>
      flags_o[4] == ($past(byte_i) ? $past(result_o[LOW_W-1]) : $past(result_o[DATA_W-1])));

  a_r3_parity_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !op_i[2]) |=> flags_o[1] == !($countones($past(result_o[7:0])) % 2));
endmodule

// File: tb/sim_arith_flag_unit.sv
module sim_arith_flag_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op = '0;
  logic        bsel = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0, upd = 1'b0;
  logic [15:0] res;
  logic [5:0]  fl;

  int n_vec = 0, n_bad = 0;
  logic [5:0] exp_fl = '0;
  bit done = 0;

  always #4 clk = ~clk;

  arith_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .byte_i(bsel), .a_i(a), .b_i(b),
    .carry_i(cin), .upd_en_i(upd), .result_o(res), .flags_o(fl)
  );

  function automatic void model(input logic [2:0] o, input logic bs, input logic [15:0] x,
                                input logic [15:0] y, input logic ci,
                                output logic [15:0] r_o, output logic [5:0] f_o);
    int w, mask, ua, ub, c, r, rn, sa, sb, sr, hi, lo;
    logic cf, af, of, zf, sf, pf;
    w = bs ? 8 : 16;
    mask = (1 << w) - 1;
    ua = int'(x) & mask;
    ub = int'(y) & mask;
    c = o[0] ? int'(ci) : 0;
    sa = (ua >= (1 << (w-1))) ? ua - (1 << w) : ua;
    sb = (ub >= (1 << (w-1))) ? ub - (1 << w) : ub;
    if (o[2]) begin
      r_o = 16'(ub);
      f_o = '0;
      return;
    end
    if (o[1]) begin
      r = ua - ub - c; rn = (ua & 15) - (ub & 15) - c; sr = sa - sb - c;
      cf = (r < 0); af = (rn < 0);
    end else begin
      r = ua + ub + c; rn = (ua & 15) + (ub & 15) + c; sr = sa + sb + c;
      cf = (r > mask); af = (rn > 15);
    end
    hi = (1 << (w-1)) - 1;
    lo = -(1 << (w-1));
    of = (sr > hi) || (sr < lo);
    r_o = 16'(r & mask);
    zf = (r_o == 16'h0);
    sf = r_o[w-1];
    pf = ~^r_o[7:0];
    f_o = {of, sf, zf, af, pf, cf};
  endfunction

  task automatic cmp(input string tag, input logic [15:0] got, input logic [15:0] want);
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: op=%0d byte=%0b a=%h b=%h cin=%0b got=%h expected=%h",
               tag, op, bsel, a, b, cin, got, want);
    end
  endtask

  task automatic check_flags(input logic [5:0] want);
    string names[6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};
    for (int i = 0; i < 6; i++) cmp(names[i], 16'(fl[i]), 16'(want[i]));
  endtask

  // drive on falling edge, check just after the next rising edge
  task automatic apply(input logic [2:0] o, input logic bs, input logic [15:0] x,
                       input logic [15:0] y, input logic ci, input logic en);
    logic [15:0] er;
    logic [5:0]  ef;
    @(negedge clk);
    op = o; bsel = bs; a = x; b = y; cin = ci; upd = en;
    model(o, bs, x, y, ci, er, ef);
    if (en && !o[2]) exp_fl = ef;
    else if (en && o == 3'd4) exp_fl[0] = 1'b1;
    else if (en && o == 3'd5) exp_fl[0] = 1'b0;
    else if (en && o == 3'd6) exp_fl[0] = ~exp_fl[0];
    @(posedge clk);
    #1;
    n_vec++;
    if (o == 3'd7)    cmp("R10", res, er);
    else if (!o[2])   cmp("R1", res, er);
    if (!en)          cmp("R8", 16'(fl), 16'(exp_fl));
    else if (o == 3'd7) cmp("R10", 16'(fl), 16'(exp_fl));
    else if (o[2])    cmp("R9", 16'(fl), 16'(exp_fl));
    else              check_flags(exp_fl);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    logic [15:0] corners[8];
    corners = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF,
                16'h7FFF, 16'h8000, 16'hFFFF};
    repeat (3) @(negedge clk);
    n_vec++;
    cmp("R11", 16'(fl), 16'h0);
    rst_ni = 1'b1;

    // R7 named example: 0x7F + 0x01 in byte mode
    apply(3'd0, 1'b1, 16'h007F, 16'h0001, 1'b0, 1'b1);
    cmp("R7", 16'(fl[5]), 16'h1);

    // byte sweep, all arithmetic codes, carry in alternating
    for (int x = 0; x < 256; x += 3)
      for (int y = 0; y < 256; y += 7)
        for (int o = 0; o < 4; o++)
          apply(3'(o), 1'b1, 16'(x) | 16'hA500, 16'(y) | 16'h5A00, 1'((x ^ y ^ o) & 1), 1'b1);

    // sign/carry boundary corners, both sizes, both carry values
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int o = 0; o < 4; o++)
          for (int s = 0; s < 2; s++) begin
            apply(3'(o), 1'(s), corners[i], corners[j], 1'b0, 1'b1);
            apply(3'(o), 1'(s), corners[i], corners[j], 1'b1, 1'b1);
          end

    // word mode pseudo-random
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 8000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[2:0] & 3'd3, 1'b0, lfsr[31:16], lfsr[15:0] ^ {lfsr[7:0], lfsr[15:8]},
            lfsr[9], 1'b1);
    end

    // R8: enable low, any operation leaves flags alone
    apply(3'd2, 1'b0, 16'h0000, 16'h0001, 1'b0, 1'b1);
    for (int k = 0; k < 40; k++)
      apply(3'(k % 8), 1'(k & 1), 16'(k * 97), 16'(k * 31), 1'(k >> 1), 1'b0);

    // R9: carry commands keep the other flags
    apply(3'd0, 1'b1, 16'h0080, 16'h0080, 1'b0, 1'b1);
    apply(3'd5, 1'b0, 16'h1234, 16'h4321, 1'b1, 1'b1);
    apply(3'd4, 1'b0, 16'h1234, 16'h4321, 1'b0, 1'b1);
    apply(3'd6, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1);
    apply(3'd6, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b1);
    apply(3'd4, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1);

    // R10: move passes b, flags untouched, both sizes
    apply(3'd7, 1'b0, 16'h1111, 16'hBEEF, 1'b1, 1'b1);
    apply(3'd7, 1'b1, 16'h1111, 16'hBEEF, 1'b1, 1'b1);

    // R11: asynchronous reset between edges
    apply(3'd1, 1'b0, 16'hFFFF, 16'h0000, 1'b1, 1'b1);
    @(negedge clk);
    upd = 1'b0;
    rst_ni = 1'b0;
    #1;
    n_vec++;
    cmp("R11", 16'(fl), 16'h0);
    exp_fl = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    apply(3'd0, 1'b0, 16'h0001, 16'h0001, 1'b0, 1'b0);

    finish_run();
  end
endmodule